// File: doc/BRIEF.md
# Multi-Width Serial Transmit Byte Queue

This block is the transmit-side byte store of a simple serial peripheral. Software feeds it through register writes. There are three push addresses. One takes a single byte, one takes a halfword and one takes a full 32-bit word, and each access enqueues 1, 2 or 4 bytes at once. A multi-byte push is split into bytes with the least-significant byte first, so the lowest byte goes out on the line first. The downstream shifter drains the queue one byte at a time over a valid/ready handshake.

Software reads the current fill level from a depth register. A push that does not fit into the free space is discarded whole, and a sticky overflow flag records the loss. A sticky pending bit with its own enable drives the interrupt output, and software clears the bit by writing 1 to it. In the default mode the pending bit is set only when the last queued byte leaves, that is, when the depth goes from one to zero. In threshold mode it is set when the depth falls from at or above a programmable level to below it. This lets software refill the queue before the line goes idle.

Register map (word addresses on `reg_addr_i`): 0 push one byte, 1 push two bytes, 2 push four bytes, 3 control, 4 status, 5 depth.

Top module: `ser_tx_queue`

## Requirements
- R1: After reset the depth reads 0, `tx_valid_o` is low, `irq_o` is low, status reads 0 and control reads 0 (drain mode, interrupt disabled, threshold 0).
- R2: A write to address 0 enqueues `reg_wdata_i[7:0]`. A write to address 1 enqueues bytes [7:0] then [15:8]. A write to address 2 enqueues bytes [7:0], [15:8], [23:16], then [31:24].
- R3: Reading address 5 returns the number of queued bytes in bits [4:0], from 0 to 16. The queue holds at most 16 bytes.
- R4: `tx_valid_o` is high exactly when the depth is nonzero. `tx_data_o` presents the oldest byte, and one byte is removed on each clock where `tx_valid_o` and `tx_ready_i` are both high.
- R5: When a push and a pop happen in the same cycle, the depth becomes the old depth plus the pushed count minus one.
- R6: A push whose byte count exceeds 16 minus the depth in that cycle is dropped entirely, and status bit 1 (overflow) is set.
- R7: The overflow flag stays set until any write to address 4 clears it.
- R8: In drain mode (control bit 0 = 0), status bit 0 (pending) is set only when the depth goes from 1 to 0. It is not set while the depth stays at 0, or while a simultaneous push and pop keep the depth at 1.
- R9: In threshold mode (control bit 0 = 1), pending is set when the depth goes from at or above control bits [8:4] to below them, and not while the depth keeps falling below that level.
- R10: Writing address 4 with bit 0 = 1 clears pending. `irq_o` equals pending AND control bit 1.
- R11: The control register reads back the mode bit 0, the enable bit 1 and the threshold in bits [8:4] as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register write address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 3 | Register read address |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tx_data_o | output | 8 | Oldest queued byte |
| tx_valid_o | output | 1 | Queue not empty |
| tx_ready_i | input | 1 | Downstream accepts a byte |
| irq_o | output | 1 | Interrupt, pending AND enable |

## Verification
The queue is filled through a mix of one-, two- and four-byte pushes and then drained in full. Comparing every byte against the expected stream shows both the lane order inside each word and the order between words. The fill pattern runs close to capacity, so a two-byte push into one free slot must be dropped while the following single byte still fits. This separates a whole-word drop from a partial write. Further cases cover a push and a pop in the same cycle at depth one, an idle empty queue, and a threshold crossing followed by a further fall below it. Together these tell a depth edge apart from a level.

// File: rtl/tx_q_pkg.sv
package tx_q_pkg;
  typedef enum logic [2:0] {
    A_PUSH8  = 3'd0,
    A_PUSH16 = 3'd1,
    A_PUSH32 = 3'd2,
    A_CTRL   = 3'd3,
    A_STAT   = 3'd4,
    A_DEPTH  = 3'd5
  } addr_e;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
  localparam int CTRL_THR_LSB  = 4;
  localparam int STAT_PEND_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;
endpackage

// File: rtl/tx_q_unpack.sv
module tx_q_unpack
  import tx_q_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  we_i,
  input  logic [2:0]            addr_i,
  input  logic [LANES*8-1:0]    wdata_i,
  input  logic [CW-1:0]         depth_i,
  output logic [NW-1:0]         push_n_o,
  output logic [LANES-1:0][7:0] push_bytes_o,
  output logic                  ovf_set_o
);
  logic [NW-1:0] req_n;
  logic [CW-1:0] free_w;
  logic          fits;

  always_comb begin
    req_n = '0;
    if (we_i) begin
      unique case (addr_e'(addr_i))
        A_PUSH8:  req_n = NW'(1);
        A_PUSH16: req_n = NW'(2);
        A_PUSH32: req_n = NW'(LANES);
        default:  req_n = '0;
      endcase
    end
  end

  // byte k of the word lands k slots after the tail
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign push_bytes_o[k] = wdata_i[k*8 +: 8];
  end

  assign free_w       = CW'(DEPTH) - depth_i;
  assign fits         = CW'(req_n) <= free_w;
  assign push_n_o     = fits ? req_n : '0;
  assign ovf_set_o    = (req_n != '0) && !fits;
endmodule

// File: rtl/tx_q_store.sv
module tx_q_store #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(LANES),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NW-1:0]         push_n_i,
  input  logic [LANES-1:0][7:0] push_bytes_i,
  input  logic                  pop_i,
  output logic [7:0]            head_o
);
  logic [AW-1:0]            wr_ptr_q, rd_ptr_q;
  logic [DEPTH-1:0][7:0]    ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(push_n_i);
      rd_ptr_q <= rd_ptr_q + AW'(pop_i);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [AW-1:0] off;
    logic [7:0]    byte_q;
    assign off = AW'(e) - wr_ptr_q;
    always_ff @(posedge clk_i) begin
      if (off < AW'(push_n_i)) byte_q <= push_bytes_i[off[LW-1:0]];
    end
    assign ent[e] = byte_q;
  end

  assign head_o = ent[rd_ptr_q];
endmodule

// File: rtl/tx_q_irq.sv
module tx_q_irq #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          thr_mode_i,
  input  logic [CW-1:0] thr_i,
  input  logic [CW-1:0] depth_q_i,
  input  logic [CW-1:0] depth_d_i,
  input  logic          clr_i,
  output logic          pend_o
);
  logic [CW-1:0] lvl;
  logic          hit;

  // drain mode is a fixed level of one
  assign lvl = thr_mode_i ? thr_i : CW'(1);
  assign hit = (depth_q_i >= lvl) && (depth_d_i < lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= hit | (pend_o & ~clr_i);
  end
endmodule

// File: rtl/ser_tx_queue.sv
module ser_tx_queue
  import tx_q_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic [2:0]        reg_raddr_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic [CW-1:0]         depth_q, depth_d, thr_q;
  logic                  thr_mode_q, irq_en_q, ovf_q, pend_q;
  logic [NW-1:0]         push_n;
  logic [LANES-1:0][7:0] push_bytes;
  logic                  ovf_set, pop, stat_wr, ctrl_wr, pend_clr;

  assign tx_valid_o = depth_q != '0;
  assign pop        = tx_valid_o & tx_ready_i;
  assign depth_d    = depth_q + CW'(push_n) - CW'(pop);
  assign stat_wr    = reg_we_i && (addr_e'(reg_addr_i) == A_STAT);
  assign ctrl_wr    = reg_we_i && (addr_e'(reg_addr_i) == A_CTRL);
  assign pend_clr   = stat_wr && reg_wdata_i[STAT_PEND_BIT];

  tx_q_unpack #(.DEPTH(DEPTH), .LANES(LANES)) u_unpack (
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .depth_i     (depth_q),
    .push_n_o    (push_n),
    .push_bytes_o(push_bytes),
    .ovf_set_o   (ovf_set)
  );

  tx_q_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (push_n),
    .push_bytes_i(push_bytes),
    .pop_i       (pop),
    .head_o      (tx_data_o)
  );

  tx_q_irq #(.DEPTH(DEPTH)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_mode_i(thr_mode_q),
    .thr_i     (thr_q),
    .depth_q_i (depth_q),
    .depth_d_i (depth_d),
    .clr_i     (pend_clr),
    .pend_o    (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q    <= '0;
      thr_q      <= '0;
      thr_mode_q <= 1'b0;
      irq_en_q   <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      depth_q <= depth_d;
      if (ctrl_wr) begin
        thr_mode_q <= reg_wdata_i[CTRL_MODE_BIT];
        irq_en_q   <= reg_wdata_i[CTRL_EN_BIT];
        thr_q      <= reg_wdata_i[CTRL_THR_LSB +: CW];
      end
      // a fresh loss wins over a clear in the same cycle
      if (ovf_set)      ovf_q <= 1'b1;
      else if (stat_wr) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr_e'(reg_raddr_i))
      A_CTRL: begin
        reg_rdata_o[CTRL_MODE_BIT]         = thr_mode_q;
        reg_rdata_o[CTRL_EN_BIT]           = irq_en_q;
        reg_rdata_o[CTRL_THR_LSB +: CW]    = thr_q;
      end
      A_STAT: begin
        reg_rdata_o[STAT_PEND_BIT] = pend_q;
        reg_rdata_o[STAT_OVF_BIT]  = ovf_q;
      end
      A_DEPTH: reg_rdata_o[CW-1:0] = depth_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = pend_q & irq_en_q;
endmodule

// File: rtl/tx_q_checker.sv
module tx_q_checker
  import tx_q_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [CW-1:0] depth_q,
  input logic          pend_q,
  input logic          ovf_q,
  input logic          thr_mode_q,
  input logic          tx_valid_o,
  input logic          tx_ready_i
);
  int req, room, pops;
  logic big;

  always_comb begin
    req = 0;
    if (reg_we_i) begin
      if (reg_addr_i == 3'd0) req = 1;
      if (reg_addr_i == 3'd1) req = 2;
      if (reg_addr_i == 3'd2) req = 4;
    end
    room = DEPTH - int'(depth_q);
    pops = (tx_valid_o && tx_ready_i) ? 1 : 0;
    big  = req > room;
  end

  assert_depth_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_q) <= DEPTH);

  assert_depth_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !big |=> int'(depth_q) == int'($past(depth_q)) + $past(req) - $past(pops));

  assert_drop_whole_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    big |=> ovf_q && int'(depth_q) == int'($past(depth_q)) - $past(pops));

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(reg_we_i && reg_addr_i == 3'd4)) |=> ovf_q);

  assert_drain_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thr_mode_q && !pend_q && !(depth_q == CW'(1) && pops == 1 && req == 0)) |=> !pend_q);
endmodule

bind ser_tx_queue tx_q_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .depth_q   (depth_q),
  .pend_q    (pend_q),
  .ovf_q     (ovf_q),
  .thr_mode_q(thr_mode_q),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i)
);

// File: tb/tb_ser_tx_queue.sv
module tb_ser_tx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic [7:0]  txd;
  logic        txv;
  logic        txr = 1'b0;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ser_tx_queue dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .tx_data_o(txd), .tx_valid_o(txv), .tx_ready_i(txr), .irq_o(irq)
  );

  // {addr, data, depth after, overflow after}
  localparam logic [40:0] VEC [8] = '{
    {3'd0, 32'h0000_00A1, 5'd1,  1'b0},
    {3'd1, 32'h0000_B2B3, 5'd3,  1'b0},
    {3'd2, 32'hC4C5_C6C7, 5'd7,  1'b0},
    {3'd2, 32'h1312_1110, 5'd11, 1'b0},
    {3'd2, 32'h1716_1514, 5'd15, 1'b0},
    {3'd1, 32'h0000_DEAD, 5'd15, 1'b1},
    {3'd0, 32'h0000_00EE, 5'd16, 1'b1},
    {3'd0, 32'h0000_0055, 5'd16, 1'b1}
  };
  localparam logic [7:0] EXP_BYTES [16] = '{
    8'hA1, 8'hB3, 8'hB2, 8'hC7, 8'hC6, 8'hC5, 8'hC4, 8'h10,
    8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'hEE
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic pop_too = 1'b0);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; txr = pop_too;
    @(negedge clk);
    we = 1'b0; txr = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk);
    txr = 1'b1;
    @(negedge clk);
    txr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd5, v); check("R1 depth", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    rd(3'd3, v); check("R1 ctrl", v, 0);
    check("R1 valid", {31'b0, txv}, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 R3 R6 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][40:38], VEC[i][37:6]);
      rd(3'd5, v); check("R3 R6 depth", v, {27'b0, VEC[i][5:1]});
      rd(3'd4, v); check("R6 overflow", {31'b0, v[1]}, {31'b0, VEC[i][0]});
    end

    // R2 R4 byte order on drain
    for (int i = 0; i < 16; i++) begin
      check("R4 valid", {31'b0, txv}, 1);
      check("R2 byte", {24'b0, txd}, {24'b0, EXP_BYTES[i]});
      pop1();
    end
    check("R4 empty", {31'b0, txv}, 0);
    rd(3'd4, v); check("R8 drain pend", {31'b0, v[0]}, 1);
    check("R7 ovf held", {31'b0, v[1]}, 1);
    check("R10 irq masked", {31'b0, irq}, 0);
    wr(3'd3, 32'h2);
    check("R10 irq enabled", {31'b0, irq}, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R7 R10 cleared", v, 0);
    check("R10 irq off", {31'b0, irq}, 0);

    // R8 idle at zero sets nothing
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R8 idle", v, 0);

    // R5 push and pop together at depth one
    wr(3'd0, 32'h31);
    wr(3'd0, 32'h32, 1'b1);
    rd(3'd5, v); check("R5 depth", v, 1);
    rd(3'd4, v); check("R8 held at one", v, 0);
    check("R4 head", {24'b0, txd}, 32'h32);
    pop1();
    rd(3'd4, v); check("R8 pend", {31'b0, v[0]}, 1);
    wr(3'd4, 32'h1);

    // R9 threshold mode, level 4
    wr(3'd3, 32'h43);
    rd(3'd3, v); check("R11 ctrl", v, 32'h43);
    wr(3'd2, 32'h4443_4241);
    rd(3'd4, v); check("R9 no pend at level", v, 0);
    pop1();
    rd(3'd4, v); check("R9 crossing", {31'b0, v[0]}, 1);
    check("R9 irq", {31'b0, irq}, 1);
    wr(3'd4, 32'h1);
    pop1();
    rd(3'd4, v); check("R9 no refire", v, 0);
    rd(3'd5, v); check("R9 depth", v, 2);
    check("R2 third byte", {24'b0, txd}, 32'h43);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(3'd5, v); check("R1 depth after", v, 0);
    rd(3'd3, v); check("R1 ctrl after", v, 0);
    check("R1 valid after", {31'b0, txv}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule